// File: doc/BRIEF.md
# Firmware Hub Bus Target

This block is the target side of a clocked, nibble-wide firmware-hub bus. The host marks the start of a frame by pulling an active-low frame strobe. After that, the host sends a fixed run of one-clock, 4-bit fields: a start code that also selects read or write, a device select, the address (most significant nibble first), a size code and, for writes, the data byte (low nibble first). The host then hands the bus over with a two-clock turnaround.

The target compares the device-select nibble with its 4-bit strap inputs. When the frame is meant for it, the target raises a single-byte request on a local memory port and holds that request until the port acknowledges. While the request is pending, the target drives wait-sync nibbles on the bus. It then drives one ready-sync nibble. For a read, the returned byte follows, low nibble first. Finally, the target drives all ones for one clock and releases the bus for one clock. Frames with an unknown start code, another device's select value or a size other than one byte are ignored until the strobe is pulled again.

The bus is split into an input, an output and an output enable, so that the pad ring can build the tri-state buffer. An active-low init input returns the target to idle and releases the bus in the same cycle.

Top module: `fwh_target`

## Requirements
- R1: While rst_ni is low, and in the first cycles after it rises with no frame, bus_oe_o and req_o are 0.
- R2: With frame_ni high and no frame in progress, any nibble on bus_i, including the start codes, leaves bus_oe_o and req_o at 0.
- R3: On a clock where frame_ni is low, bus_i is the start code: 4'hD begins a read and 4'hE begins a write. Any other value makes the target ignore the frame, with no request and no drive, until frame_ni is low again.
- R4: The nibble after the start code is the device select. The frame is served only when it equals id_i; otherwise it is ignored.
- R5: The next ADDR_NIB nibbles form addr_o, most significant nibble first. addr_o stays stable while req_o is high.
- R6: The nibble after the address is the size code. Only 4'h0 (one byte) is served; any other value makes the target ignore the frame.
- R7: A write takes two data nibbles after the size code, low nibble first, and presents them on wdata_o. After two host turnaround clocks, req_o rises with we_o at 1. For a read, req_o rises with we_o at 0 two clocks after the size code.
- R8: Each clock that req_o is high, the target drives 4'h6 (wait). The clock on which ack_i is seen high is the last one. On the next clock req_o is low and the target drives 4'h0 (ready).
- R9: For a read, the two clocks after the ready nibble carry the byte taken from rdata_i on the acknowledge clock: first bits 3:0, then bits 7:4.
- R10: After the ready nibble (write) or the second read data nibble, the target drives 4'hF for one clock. It then releases the bus and returns to idle. At no point does it drive while the host is driving.
- R11: When init_ni is low, bus_oe_o and req_o fall in the same cycle and the target is idle after the next clock edge.
- R12: A frame_ni low clock in the middle of a frame abandons that frame and starts decoding a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_ni | input | 1 | Active-low init; forces idle and releases the bus |
| frame_ni | input | 1 | Active-low frame strobe |
| id_i | input | 4 | Device select strap |
| bus_i | input | 4 | Nibble bus as seen at the pad |
| bus_o | output | 4 | Nibble driven by the target |
| bus_oe_o | output | 1 | Target output enable for the bus |
| req_o | output | 1 | Local byte request, held until acknowledged |
| we_o | output | 1 | 1 for a write request, 0 for a read |
| addr_o | output | 4*ADDR_NIB | Byte address of the request |
| wdata_o | output | 8 | Write byte |
| ack_i | input | 1 | Local port acknowledge |
| rdata_i | input | 8 | Read byte, valid with ack_i |

## Verification
The sequencer state is registered and the bus outputs are decoded from it. Each host nibble is therefore consumed on the clock edge that ends its cycle, and the target's response shows one cycle later. The request and the first wait nibble appear two cycles after the size code for a read, or two cycles after the high data nibble for a write. The ready nibble follows one cycle after the acknowledge. Each read data nibble, the all-ones turnaround and the release then follow one cycle apart. The bench drives each nibble after a falling edge and samples after the next falling edge, so every expected value is checked exactly one edge after its cause. The exceptions are init, which releases the bus combinationally and is checked before any edge, and the ignored frames, whose outputs are watched on every cycle of the rest of the frame.

// File: rtl/fwh_tgt_pkg.sv
package fwh_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ID, ST_ADDR, ST_SIZE, ST_WLO, ST_WHI, ST_HTAR1, ST_HTAR2,
    ST_SWAIT, ST_SRDY, ST_RLO, ST_RHI, ST_TTAR1, ST_TTAR2
  } st_e;

  localparam logic [3:0] NIB_START_RD  = 4'hD;
  localparam logic [3:0] NIB_START_WR  = 4'hE;
  localparam logic [3:0] NIB_SIZE_BYTE = 4'h0;
  localparam logic [3:0] NIB_SYNC_WAIT = 4'h6;
  localparam logic [3:0] NIB_SYNC_RDY  = 4'h0;
  localparam logic [3:0] NIB_TAR       = 4'hF;
endpackage

// File: rtl/fwh_tgt_seq.sv
module fwh_tgt_seq
  import fwh_tgt_pkg::*;
#(
  parameter int ADDR_NIB = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_ni,
  input  logic       frame_ni,
  input  logic [3:0] bus_i,
  input  logic [3:0] id_i,
  input  logic       ack_i,
  output st_e        state_o,
  output logic       wr_o
);
  localparam int CNT_W = $clog2(ADDR_NIB + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIB - 1);

  st_e st_q, st_d;
  logic wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (!init_ni) begin
      st_d = ST_IDLE;
    end else if (!frame_ni) begin
      // strobe low restarts decode from any state
      st_d = (bus_i == NIB_START_RD || bus_i == NIB_START_WR) ? ST_ID : ST_IDLE;
      wr_d = (bus_i == NIB_START_WR);
    end else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_IDLE;
        ST_ID: begin
          st_d  = (bus_i == id_i) ? ST_ADDR : ST_IDLE;
          cnt_d = '0;
        end
        ST_ADDR: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) st_d = ST_SIZE;
        end
        ST_SIZE:  st_d = (bus_i != NIB_SIZE_BYTE) ? ST_IDLE : (wr_q ? ST_WLO : ST_HTAR1);
        ST_WLO:   st_d = ST_WHI;
        ST_WHI:   st_d = ST_HTAR1;
        ST_HTAR1: st_d = ST_HTAR2;
        ST_HTAR2: st_d = ST_SWAIT;
        ST_SWAIT: if (ack_i) st_d = ST_SRDY;
        ST_SRDY:  st_d = wr_q ? ST_TTAR1 : ST_RLO;
        ST_RLO:   st_d = ST_RHI;
        ST_RHI:   st_d = ST_TTAR1;
        ST_TTAR1: st_d = ST_TTAR2;
        ST_TTAR2: st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      wr_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign wr_o    = wr_q;

  AST_ADDR_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR) |-> (cnt_q <= CNT_LAST)) else $error("addr count overrun"); // R5
endmodule

// File: rtl/fwh_tgt_capture.sv
module fwh_tgt_capture
  import fwh_tgt_pkg::*;
#(
  parameter int ADDR_NIB = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  st_e                   state_i,
  input  logic [3:0]            bus_i,
  input  logic                  ack_i,
  input  logic [7:0]            rdata_i,
  output logic [4*ADDR_NIB-1:0] addr_o,
  output logic [7:0]            wdata_o,
  output logic [7:0]            rdata_o
);
  localparam int ADDR_W = 4 * ADDR_NIB;

  logic [ADDR_W-1:0] addr_q;
  logic [7:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (state_i == ST_ADDR) begin
        if (ADDR_NIB > 1) addr_q <= {addr_q[ADDR_W-5:0], bus_i};
        else              addr_q <= ADDR_W'(bus_i);
      end
      if (state_i == ST_WLO) wdata_q[3:0] <= bus_i;
      if (state_i == ST_WHI) wdata_q[7:4] <= bus_i;
      if (state_i == ST_SWAIT && ack_i) rdata_q <= rdata_i;
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/fwh_tgt_drive.sv
module fwh_tgt_drive
  import fwh_tgt_pkg::*;
(
  input  st_e        state_i,
  input  logic       init_ni,
  input  logic [7:0] rdata_i,
  output logic [3:0] bus_o,
  output logic       bus_oe_o
);
  logic drv;

  always_comb begin
    drv   = 1'b1;
    bus_o = NIB_TAR;
    unique case (state_i)
      ST_SWAIT: bus_o = NIB_SYNC_WAIT;
      ST_SRDY:  bus_o = NIB_SYNC_RDY;
      ST_RLO:   bus_o = rdata_i[3:0];
      ST_RHI:   bus_o = rdata_i[7:4];
      ST_TTAR1: bus_o = NIB_TAR;
      default:  drv   = 1'b0;
    endcase
  end

  // init releases the pad without waiting for a clock
  assign bus_oe_o = drv & init_ni;
endmodule

// File: rtl/fwh_target.sv
module fwh_target
  import fwh_tgt_pkg::*;
#(
  parameter int ADDR_NIB = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  init_ni,
  input  logic                  frame_ni,
  input  logic [3:0]            id_i,
  input  logic [3:0]            bus_i,
  output logic [3:0]            bus_o,
  output logic                  bus_oe_o,
  output logic                  req_o,
  output logic                  we_o,
  output logic [4*ADDR_NIB-1:0] addr_o,
  output logic [7:0]            wdata_o,
  input  logic                  ack_i,
  input  logic [7:0]            rdata_i
);
  st_e state;
  logic wr;
  logic [7:0] rdata_q;

  fwh_tgt_seq #(.ADDR_NIB(ADDR_NIB)) u_seq (
    .clk_i, .rst_ni, .init_ni, .frame_ni, .bus_i, .id_i, .ack_i,
    .state_o(state), .wr_o(wr)
  );

  fwh_tgt_capture #(.ADDR_NIB(ADDR_NIB)) u_cap (
    .clk_i, .rst_ni, .state_i(state), .bus_i, .ack_i, .rdata_i,
    .addr_o, .wdata_o, .rdata_o(rdata_q)
  );

  fwh_tgt_drive u_drv (
    .state_i(state), .init_ni, .rdata_i(rdata_q), .bus_o, .bus_oe_o
  );

  assign req_o = (state == ST_SWAIT) & init_ni;
  assign we_o  = wr;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && init_ni && frame_ni) |=> req_o) else $error("req dropped"); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && init_ni && frame_ni) |=> $stable(addr_o)) else $error("addr moved"); // R5
  AST_ACK_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && init_ni && frame_ni) |=> (!req_o && bus_oe_o && bus_o == NIB_SYNC_RDY))
    else $error("no ready sync"); // R8
  AST_INIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_ni |=> (!bus_oe_o && !req_o)) else $error("init not honoured"); // R11
  AST_TAR_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_TTAR1 && bus_oe_o && frame_ni) |=> !bus_oe_o) else $error("no float"); // R10
  AST_BAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_ni && !frame_ni && bus_i != NIB_START_RD && bus_i != NIB_START_WR)
      |=> (!bus_oe_o && !req_o)) else $error("bad start served"); // R3
endmodule

// File: tb/fwh_target_tb.sv
`timescale 1ns/1ps
module fwh_target_tb_top;
  localparam int CLK_PERIOD = 30;
  localparam int ADDR_NIB = 7;
  localparam logic [3:0] STRAP = 4'h2;

  typedef struct packed {
    logic [3:0]  start;
    logic [3:0]  id;
    logic [27:0] addr;
    logic [3:0]  size;
    logic [7:0]  data;
    logic [3:0]  waits;
    logic        resp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{4'hD, 4'h2, 28'h0FFFF00, 4'h0, 8'hA5, 4'd0, 1'b1},
    '{4'hE, 4'h2, 28'h1234567, 4'h0, 8'h3C, 4'd2, 1'b1},
    '{4'hD, 4'h2, 28'hFFFFFFF, 4'h0, 8'h81, 4'd3, 1'b1},
    '{4'hD, 4'h0, 28'h0000010, 4'h0, 8'h11, 4'd0, 1'b0},
    '{4'h0, 4'h2, 28'h00000D0, 4'h0, 8'h22, 4'd0, 1'b0},
    '{4'hD, 4'h2, 28'h0000020, 4'h1, 8'h33, 4'd0, 1'b0},
    '{4'hE, 4'h2, 28'h8000001, 4'h0, 8'hF0, 4'd0, 1'b1},
    '{4'hC, 4'h2, 28'h0E0E0E0, 4'h0, 8'h44, 4'd1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, init_n = 1'b1, frame_n = 1'b1;
  logic host_oe = 1'b0, ack = 1'b0;
  logic [3:0] host_nib = 4'hF;
  logic [7:0] rdata = 8'h00;
  logic [3:0] bus_w, dut_bus;
  logic dut_oe, req, we;
  logic [27:0] addr;
  logic [7:0] wdata;
  int checks = 0, fails = 0;
  bit contention = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_w = dut_oe ? dut_bus : (host_oe ? host_nib : 4'hF);

  fwh_target #(.ADDR_NIB(ADDR_NIB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .init_ni(init_n), .frame_ni(frame_n), .id_i(STRAP),
    .bus_i(bus_w), .bus_o(dut_bus), .bus_oe_o(dut_oe), .req_o(req), .we_o(we),
    .addr_o(addr), .wdata_o(wdata), .ack_i(ack), .rdata_i(rdata)
  );

  always @(negedge clk) if (dut_oe && host_oe) contention = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_quiet(input string tag);
    chk(!dut_oe && !req, tag, {dut_oe, req}, 0);
  endtask

  task automatic send_hdr(input vec_t v);
    host_oe = 1'b1; frame_n = 1'b0; host_nib = v.start; tick;
    frame_n = 1'b1; host_nib = v.id; tick;
    for (int i = ADDR_NIB - 1; i >= 0; i--) begin host_nib = v.addr[i*4 +: 4]; tick; end
    host_nib = v.size; tick;
    if (v.resp) begin
      if (v.start == 4'hE) begin
        host_nib = v.data[3:0]; tick;
        host_nib = v.data[7:4]; tick;
      end
      host_nib = 4'hF; tick;
      host_oe = 1'b0; tick;
    end
  endtask

  task automatic run_frame(input vec_t v);
    bit wr;
    wr = (v.start == 4'hE);
    send_hdr(v);
    if (!v.resp) begin
      host_nib = 4'hF;
      for (int i = 0; i < 8; i++) begin chk_quiet("R3/R4/R6 ignored frame"); tick; end
      host_oe = 1'b0;
      return;
    end
    chk(req && we == wr && addr == v.addr, "R5/R7 request", {3'b0, req, we, addr}, {4'b1, wr, v.addr});
    if (wr) chk(wdata == v.data, "R7 wdata", wdata, v.data);
    for (int i = 0; i < int'(v.waits); i++) begin
      chk(dut_oe && dut_bus == 4'h6 && req, "R8 wait sync", {dut_oe, req, dut_bus}, 6'h36);
      tick;
    end
    ack = 1'b1; rdata = v.data;
    chk(dut_oe && dut_bus == 4'h6 && req, "R8 wait on ack clock", {dut_oe, req, dut_bus}, 6'h36);
    tick;
    ack = 1'b0; rdata = ~v.data;
    chk(dut_oe && !req && dut_bus == 4'h0, "R8 ready sync", {dut_oe, req, dut_bus}, 6'h20);
    tick;
    if (!wr) begin
      chk(dut_oe && dut_bus == v.data[3:0], "R9 low nibble", {dut_oe, dut_bus}, {1'b1, v.data[3:0]});
      tick;
      chk(dut_oe && dut_bus == v.data[7:4], "R9 high nibble", {dut_oe, dut_bus}, {1'b1, v.data[7:4]});
      tick;
    end
    chk(dut_oe && dut_bus == 4'hF, "R10 drive ones", {dut_oe, dut_bus}, 5'h1F);
    tick;
    chk(!dut_oe, "R10 float", dut_oe, 0);
    tick;
    chk_quiet("R10 back to idle");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_quiet("R1 in reset");
    rst_n = 1'b1;
    tick; tick;
    chk_quiet("R1 after reset");

    // R2: nibbles with frame high, including start codes and strap value
    host_oe = 1'b1;
    for (int i = 0; i < 10; i++) begin
      host_nib = (i % 2 == 0) ? 4'hD : 4'(i);
      tick;
      chk_quiet("R2 idle with frame high");
    end
    host_oe = 1'b0;

    for (int n = 0; n < NVEC; n++) run_frame(VECS[n]);

    // R12: abort a write mid-address, then a full read
    host_oe = 1'b1; frame_n = 1'b0; host_nib = 4'hE; tick;
    frame_n = 1'b1; host_nib = STRAP; tick;
    host_nib = 4'h7; tick; host_nib = 4'h7; tick;
    run_frame('{4'hD, 4'h2, 28'h0ABCDEF, 4'h0, 8'h5E, 4'd1, 1'b1});
    chk(1'b1, "R12 restart decoded", 0, 0);

    // R11: init during a pending request
    send_hdr('{4'hD, 4'h2, 28'h0000001, 4'h0, 8'h00, 4'd0, 1'b1});
    chk(req && dut_oe, "R11 pending before init", {req, dut_oe}, 2'b11);
    init_n = 1'b0; #1;
    chk_quiet("R11 same-cycle release");
    tick;
    init_n = 1'b1; #1;
    chk_quiet("R11 idle after init");
    for (int i = 0; i < 4; i++) begin tick; chk_quiet("R11 stays idle"); end
    run_frame('{4'hE, 4'h2, 28'h0000002, 4'h0, 8'h69, 4'd0, 1'b1});

    chk(!contention, "R10 no bus contention", contention, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule